// File: doc/BRIEF.md
# Sample Capture Buffer Controller

This block runs a single-shot acquisition through an external asynchronous byte-wide SRAM. When it gets a start pulse, it produces a clock for an external 8-bit converter at half the controller rate. It enables the converter's output drivers onto the shared memory data bus. It sweeps the address counter across the whole memory, pulsing the SRAM write enable once per sample, so each converter byte lands at the next location.

When the sweep wraps past the top address, the block leaves one quiet clock. It then reads the memory back from address zero with the SRAM output enable asserted. Each byte is latched and handed to a parallel USB FIFO. A byte is written only while the FIFO's active-low transmit-empty input reports room, and the write strobe is held for a programmable number of clocks. After the last byte, a done flag rises and the block goes idle.

A clear input aborts any phase and returns the address counter to zero.

Top module: `capture_buf_ctrl`

## Requirements
- R1: After reset, or in the clock after `clear_i` is sampled high (clear takes priority over start), the address is 0, every strobe is inactive (`adc_clk_o`=0, `sram_we_no`=1, `sram_oe_no`=1, `adc_oe_no`=1, `usb_wr_o`=0), and `busy_o` and `done_o` are 0.
- R2: A one-clock `start_i` pulse in idle makes `busy_o` and `adc_clk_o` high and `done_o` low in the next clock. Capture begins at address 0.
- R3: During capture, `adc_clk_o` is high for one clock and low for the next. The address steps up by one in each clock where `adc_clk_o` rises, so it changes once every two clocks.
- R4: `sram_we_no` is low exactly in the clock that follows each `adc_clk_o` high clock. The address is unchanged during that clock, and `adc_oe_no` is low through the whole capture.
- R5: After address 2^ADDR_W-1 is written, the address wraps to 0 and readout begins with no further input. Every address is written exactly once per capture.
- R6: `sram_we_no` and `sram_oe_no` are never low together, and `adc_oe_no` is high whenever `sram_oe_no` is low. At least one clock with both SRAM strobes high separates the last write from the first read.
- R7: Readout delivers bytes in ascending address order from 0. Each byte equals the converter sample stored at that address.
- R8: `usb_wr_o` rises only in the clock after `usb_txe_ni` was sampled low, and then stays high for exactly STB_CYC clocks. While `usb_txe_ni` stays high, no strobe is issued.
- R9: `usb_data_o` is constant from before `usb_wr_o` rises through the clock after it falls. The address holds for that clock and only then advances.
- R10: After the last byte's strobe is released, `done_o` goes high and `busy_o` goes low. `done_o` stays high until the next start or clear.
- R11: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a capture (idle only) |
| clear_i | input | 1 | Abort and zero the address counter |
| adc_clk_o | output | 1 | Converter sample clock, half rate |
| adc_oe_no | output | 1 | Converter bus drive enable, active low |
| sram_addr_o | output | ADDR_W | Shared SRAM address |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| sram_data_i | input | DATA_W | SRAM read data |
| usb_txe_ni | input | 1 | USB FIFO has room, active low |
| usb_wr_o | output | 1 | USB FIFO write strobe |
| usb_data_o | output | DATA_W | Byte presented to the USB FIFO |
| busy_o | output | 1 | Capture or readout in progress |
| done_o | output | 1 | Last capture fully transferred |

## Verification
A wrong sequencer state shows at the ports within one clock, because every strobe is a direct decode of that state. The per-clock comparison against the bench model therefore catches a skipped or repeated phase in the very cycle it occurs. A wrong address or a mistimed latch is different: it leaves every strobe pattern correct and only surfaces as a wrong or misordered byte at the USB side. For that reason the received byte stream is checked in full against the converter sample sequence after each capture. Handshake faults, such as a strobe issued without room or a strobe of the wrong length, appear on the first byte that is affected.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CAP_HI,
    S_CAP_WR,
    S_GAP,
    S_RD_ADDR,
    S_RD_WAIT,
    S_RD_STB,
    S_RD_REL
  } scb_state_e;
endpackage

// File: rtl/scb_addr_ctr.sv
module scb_addr_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;  // wraps at the top
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;
endmodule

// File: rtl/scb_seq.sv
module scb_seq
  import scb_pkg::*;
#(
  parameter int STB_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       txe_ni,
  input  logic       last_i,
  output scb_state_e state_o,
  output logic       inc_o,
  output logic       load_o,
  output logic       done_o
);
  localparam int STB_W = (STB_CYC > 2) ? $clog2(STB_CYC) : 1;
  localparam logic [STB_W-1:0] STB_LAST = STB_W'(STB_CYC - 1);

  scb_state_e       state_q, state_d;
  logic [STB_W-1:0] stb_q, stb_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    stb_d   = stb_q;
    done_d  = done_q;
    inc_o   = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_CAP_HI;
        done_d  = 1'b0;
      end
      S_CAP_HI: state_d = S_CAP_WR;
      S_CAP_WR: begin
        inc_o   = 1'b1;
        state_d = last_i ? S_GAP : S_CAP_HI;
      end
      S_GAP: state_d = S_RD_ADDR;
      S_RD_ADDR: begin
        load_o  = 1'b1;
        state_d = S_RD_WAIT;
      end
      S_RD_WAIT: if (!txe_ni) begin
        state_d = S_RD_STB;
        stb_d   = '0;
      end
      S_RD_STB: begin
        if (stb_q == STB_LAST) state_d = S_RD_REL;
        else                   stb_d   = stb_q + 1'b1;
      end
      S_RD_REL: begin
        inc_o = 1'b1;
        if (last_i) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = S_RD_ADDR;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (clear_i) begin
      state_d = S_IDLE;
      done_d  = 1'b0;
      inc_o   = 1'b0;
      load_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      stb_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/capture_buf_ctrl.sv
module capture_buf_ctrl
  import scb_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int STB_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  output logic              adc_clk_o,
  output logic              adc_oe_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  input  logic [DATA_W-1:0] sram_data_i,
  input  logic              usb_txe_ni,
  output logic              usb_wr_o,
  output logic [DATA_W-1:0] usb_data_o,
  output logic              busy_o,
  output logic              done_o
);
  scb_state_e        state;
  logic              inc, load, last;
  logic [DATA_W-1:0] data_q;

  scb_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .inc_i  (inc),
    .addr_o (sram_addr_o),
    .last_o (last)
  );

  scb_seq #(.STB_CYC(STB_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .clear_i (clear_i),
    .txe_ni  (usb_txe_ni),
    .last_i  (last),
    .state_o (state),
    .inc_o   (inc),
    .load_o  (load),
    .done_o  (done_o)
  );

  // byte held for the USB FIFO across wait, strobe and release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (clear_i) data_q <= '0;
    else if (load)    data_q <= sram_data_i;
  end

  assign adc_clk_o  = (state == S_CAP_HI);
  assign adc_oe_no  = !((state == S_CAP_HI) || (state == S_CAP_WR));
  assign sram_we_no = (state != S_CAP_WR);
  assign sram_oe_no = !((state == S_RD_ADDR) || (state == S_RD_WAIT) ||
                        (state == S_RD_STB)  || (state == S_RD_REL));
  assign usb_wr_o   = (state == S_RD_STB);
  assign usb_data_o = data_q;
  assign busy_o     = (state != S_IDLE);
endmodule

// File: rtl/capture_buf_ctrl_chk.sv
module capture_buf_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              adc_clk_o,
  input logic              adc_oe_no,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              usb_txe_ni,
  input logic              usb_wr_o,
  input logic [DATA_W-1:0] usb_data_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r1_clear_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sram_addr_o == '0) && !busy_o && !done_o && sram_we_no && sram_oe_no);

  a_r3_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_o |=> !adc_clk_o);

  a_r4_we_after_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(adc_clk_o));

  a_r4_addr_stable_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> $stable(sram_addr_o));

  a_r6_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  a_r6_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> adc_oe_no);

  a_r6_quiet_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_no) |-> $past(sram_we_no));

  a_r8_room_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(usb_wr_o) |-> $past(!usb_txe_ni));

  a_r8_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(usb_wr_o) && !$past(clear_i)) |-> $past(usb_wr_o, 2));

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_wr_o || ($fell(usb_wr_o) && !$past(clear_i))) |-> $stable(usb_data_o));

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(usb_wr_o) && !$past(clear_i)) |-> $stable(sram_addr_o));
endmodule

bind capture_buf_ctrl capture_buf_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .adc_clk_o   (adc_clk_o),
  .adc_oe_no   (adc_oe_no),
  .sram_addr_o (sram_addr_o),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .usb_txe_ni  (usb_txe_ni),
  .usb_wr_o    (usb_wr_o),
  .usb_data_o  (usb_data_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_capture_buf_ctrl.sv
module tb_capture_buf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int STB_CYC    = 2;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int MAX        = DEPTH - 1;
  localparam int WDOG       = 50000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clear = 1'b0, txe = 1'b0;
  logic adc_clk, adc_oe_n, we_n, oe_n, usb_wr, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] sram_rd, usb_data, adc_bus = '0;
  logic [DATA_W-1:0] mem [DEPTH];

  int total = 0, bad = 0, cyc = 0, conv_n = 0, txe_mode = 0;
  int m_ph = 0, m_addr = 0, m_stb = 0, m_done = 0, m_data = 0;
  logic wr_d = 1'b0;
  int got[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_buf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_CYC(STB_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clear),
    .adc_clk_o(adc_clk), .adc_oe_no(adc_oe_n), .sram_addr_o(addr),
    .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_data_i(sram_rd),
    .usb_txe_ni(txe), .usb_wr_o(usb_wr), .usb_data_o(usb_data),
    .busy_o(busy), .done_o(done)
  );

  function automatic int sample_of(int n);
    return (n * 37 + 11) % 256;
  endfunction

  // converter: new byte after each sample clock rise
  always @(posedge adc_clk) begin
    conv_n++;
    adc_bus = DATA_W'(sample_of(conv_n));
  end

  // SRAM
  always @(posedge clk) if (!we_n && !adc_oe_n) mem[addr] <= adc_bus;
  assign sram_rd = !oe_n ? mem[addr] : '0;

  // USB FIFO: one byte per strobe
  always @(posedge clk) begin
    if (usb_wr && !wr_d) got.push_back(int'(usb_data));
    wr_d <= usb_wr;
  end

  always @(negedge clk)
    case (txe_mode)
      0: txe = 1'b0;
      1: txe = 1'($urandom % 2);
      default: txe = 1'b1;
    endcase

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      total++; bad++;
      $display("FAIL R10 watchdog cycles=%0d expected<=%0d", cyc, WDOG);
      summary();
    end
  end

  // behavioural reference: phase 0 idle,1 sample,2 write,3 gap,4 addr,5 wait,6 strobe,7 release
  always @(posedge clk) begin
    if (!rst_n || clear) begin
      m_ph = 0; m_addr = 0; m_stb = 0; m_done = 0; m_data = 0;
    end else begin
      case (m_ph)
        0: if (start) begin m_ph = 1; m_done = 0; end
        1: m_ph = 2;
        2: if (m_addr == MAX) begin m_addr = 0; m_ph = 3; end
           else begin m_addr++; m_ph = 1; end
        3: m_ph = 4;
        4: begin m_data = int'(mem[m_addr]); m_ph = 5; end
        5: if (!txe) begin m_ph = 6; m_stb = 1; end
        6: if (m_stb == STB_CYC) m_ph = 7; else m_stb++;
        default: if (m_addr == MAX) begin m_addr = 0; m_ph = 0; m_done = 1; end
                 else begin m_addr++; m_ph = 4; end
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 addr", int'(addr), m_addr);
    chk("R3 adc_clk", int'(adc_clk), int'(m_ph == 1));
    chk("R4 we_n", int'(we_n), int'(m_ph != 2));
    chk("R4 adc_oe_n", int'(adc_oe_n), int'(!(m_ph == 1 || m_ph == 2)));
    chk("R6 oe_n", int'(oe_n), int'(m_ph < 4));
    chk("R8 usb_wr", int'(usb_wr), int'(m_ph == 6));
    chk("R2 busy", int'(busy), int'(m_ph != 0));
    chk("R10 done", int'(done), m_done);
    if (m_ph >= 5) chk("R9 usb_data", int'(usb_data), m_data);
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    chk("R10 done_seen", int'(done), 1);
    chk("R10 idle", int'(busy), 0);
  endtask

  task automatic run_full(int mode, bit extra_start);
    int base;
    got.delete();
    txe_mode = mode;
    base = conv_n;
    pulse(start);
    if (extra_start) begin
      repeat (9) @(negedge clk);
      pulse(start);  // R11: must be ignored
    end
    wait_done();
    chk("R5 count", got.size(), DEPTH);
    for (int a = 0; a < DEPTH && a < got.size(); a++)
      chk("R7 byte", got[a], sample_of(base + a + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset strobes", int'({adc_clk, we_n, oe_n, adc_oe_n, usb_wr, busy, done}), 'b0111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pulse(clear);
    run_full(0, 1'b0);   // FIFO always ready
    run_full(1, 1'b1);   // random room, stray start (R11)

    // R8: no room held for a while, no strobe may appear
    got.delete();
    txe_mode = 2;
    pulse(start);
    repeat (2 * DEPTH + 40) @(negedge clk);
    chk("R8 no room pushes", got.size(), 0);
    chk("R8 waiting oe", int'(oe_n), 0);
    txe_mode = 0;
    wait_done();
    chk("R5 late count", got.size(), DEPTH);

    // R1: abort mid-capture
    pulse(start);
    repeat (15) @(negedge clk);
    clear = 1'b1; start = 1'b1;
    @(negedge clk);
    clear = 1'b0; start = 1'b0;
    chk("R1 clear addr", int'(addr), 0);
    chk("R1 clear busy", int'(busy), 0);
    chk("R1 clear we_n", int'(we_n), 1);
    repeat (3) @(negedge clk);
    run_full(1, 1'b0);

    repeat (5) @(negedge clk);
    chk("R10 done held", int'(done), 1);
    summary();
  end
endmodule